// File: doc/BRIEF.md
# Two-Bridge Chopper Current Controller

This block is the digital control core for the two H-bridges that drive the windings of a bipolar stepper motor. Each bridge has a direction input and a 2-bit current-level code. For each bridge the block produces four gate enables: two high-side and two low-side. It also produces a 2-bit threshold select, which tells an external sense comparator which of four current levels to regulate to. The comparator's digital trip signal comes back to the block. The power stages, the comparators and the oscillator are outside the block. The oscillator arrives as a one-cycle clock-enable tick.

Every oscillator tick starts a chopping period. Bridge 0 starts its period on the tick itself. Bridge 1 starts its period a fixed number of cycles later, so the two bridges never switch on together. Within a period the sink transistor conducts until the comparator trips. The sink then stays off until the next period start, while the source transistor stays on so the winding current recirculates slowly.

When the direction of a bridge reverses, even because of a one-cycle glitch, the block switches all four transistors of that bridge off for a programmable break-before-make interval. The winding current then decays fast. When both level codes are zero, the block parks every output and raises a low-power status output.

Top module: `stepper_chop_ctrl`

## Requirements
- R1: `thr_sel[2b+1:2b]` carries the synchronised level code of bridge b. The codes are 00 = no current, 01 = hold, 10 = set and 11 = accelerate, and they select the 0 V, 0.07 V, 0.45 V and 0.70 V comparator references respectively.
- R2: When both synchronised level codes are 00, `inhibit_o` is 1 and every bit of `hs_en`, `ls_en` and `thr_sel` is 0. Otherwise `inhibit_o` is 0.
- R3: A bridge whose code is 00 keeps its four enables at 0 while the other bridge is driving.
- R4: Bridge b has side 1 on bit 2b and side 2 on bit 2b+1 of `hs_en` and of `ls_en`. When `dir_in[b]` is 1, current flows from side 1 to side 2: `hs_en[2b]` is on and the sink is `ls_en[2b+1]`. When `dir_in[b]` is 0, `hs_en[2b+1]` is on and the sink is `ls_en[2b]`.
- R5: The high-side and low-side enables of the same half-bridge are never 1 together.
- R6: A tick sampled on clock edge t turns on the sink of bridge 0 at edge t. It turns on the sink of bridge 1 at edge t+PHASE_OFS_CYCLES.
- R7: A trip of bridge b sampled at an edge turns that bridge's sink off from that edge onwards, while its high side stays on. The sink stays off until the next period start of that bridge.
- R8: A direction change that reaches the synchroniser output keeps the old drive for one more cycle. All four enables of the bridge are then 0 for BBM_CYCLES cycles. After that the new direction is driven with the sink on.
- R9: A direction pulse of one cycle also causes the all-off interval. The interval restarts on the returning edge, so the bridge is off for BBM_CYCLES+1 cycles and then resumes its original direction.
- R10: A change on `lvl_in` or `dir_in` reaches the decoding logic through two flip-flops, so `thr_sel` and `inhibit_o` follow the new code two clock edges after it is driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle chopping oscillator tick |
| dir_in | input | 2 | Direction per bridge (bit b = bridge b) |
| lvl_in | input | 4 | Level code per bridge, bits [2b+1:2b] |
| trip_in | input | 2 | Comparator trip per bridge |
| hs_en | output | 4 | High-side enables, bit 2b side 1, bit 2b+1 side 2 |
| ls_en | output | 4 | Low-side enables, same bit layout |
| thr_sel | output | 4 | Threshold select per bridge |
| inhibit_o | output | 1 | Low-power status: all outputs parked |

## Verification
The bench sweeps every combination of the two level codes with every combination of the two directions. After each setting it fires one tick and checks the full gate pattern of both bridges. This separates a swapped side, a wrong sink and a bridge that leaks current while its code is zero. Directed sequences cover the rest:
- Trips arriving mid-period and the staggered sink turn-on after a tick, which together tell the trip-to-tick hold apart from the bridge-to-bridge offset.
- Direction reversals and one-cycle direction glitches, checked at the first and last cycle of the all-off interval.
- Level-code steps sampled one and two edges after they are driven, which pin down the synchroniser latency.

// File: rtl/stpc_pkg.sv
package stpc_pkg;

  typedef enum logic [1:0] {
    LVL_OFF   = 2'b00,
    LVL_HOLD  = 2'b01,
    LVL_SET   = 2'b10,
    LVL_ACCEL = 2'b11
  } lvl_e;

  typedef struct packed {
    logic hi_s2;
    logic hi_s1;
    logic lo_s2;
    logic lo_s1;
  } gate_t;

  // Source on the side current leaves from, sink on the other side.
  function automatic gate_t gate_pattern(input logic dir, input logic sink_on);
    gate_t g;
    g = '0;
    if (dir) begin
      g.hi_s1 = 1'b1;
      g.lo_s2 = sink_on;
    end else begin
      g.hi_s2 = 1'b1;
      g.lo_s1 = sink_on;
    end
    return g;
  endfunction

  // The comparator reference index equals the level code.
  function automatic logic [1:0] thr_of(input lvl_e lvl);
    return logic'(lvl != LVL_OFF) ? 2'(lvl) : 2'b00;
  endfunction

endpackage

// File: rtl/stpc_sync2.sv
module stpc_sync2 #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/stpc_phase_skew.sv
module stpc_phase_skew #(
  parameter int unsigned OFS_CYC = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  output logic [1:0] start
);
  assign start[0] = tick;

  generate
    if (OFS_CYC == 0) begin : g_aligned
      assign start[1] = tick;
    end else begin : g_delayed
      localparam int CW = $clog2(OFS_CYC + 1);
      logic [CW-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt <= '0;
        else if (tick)           cnt <= CW'(OFS_CYC);
        else if (cnt != '0)      cnt <= cnt - CW'(1);
      end

      assign start[1] = (cnt == CW'(1));
    end
  endgenerate
endmodule

// File: rtl/stpc_bridge.sv
module stpc_bridge
  import stpc_pkg::*;
#(
  parameter int unsigned BBM_CYC = 400
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dir_s,
  input  logic [1:0] lvl_s,
  input  logic       start,
  input  logic       trip,
  output gate_t      gate,
  output logic [1:0] thr,
  output logic       bbm_busy,
  output logic       bbm_done
);
  localparam int BW = $clog2(BBM_CYC + 1);

  logic          dir_q;
  logic [BW-1:0] bbm_cnt;
  logic          sink_on;
  logic          en;
  logic          dir_chg;

  assign en       = (lvl_e'(lvl_s) != LVL_OFF);
  assign dir_chg  = (dir_s != dir_q);
  assign bbm_busy = (bbm_cnt != '0);
  assign bbm_done = (bbm_cnt == BW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= 1'b0;
      bbm_cnt <= '0;
    end else begin
      dir_q <= dir_s;
      if (dir_chg)       bbm_cnt <= BW'(BBM_CYC);
      else if (bbm_busy) bbm_cnt <= bbm_cnt - BW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sink_on <= 1'b0;
    else if (!en)      sink_on <= 1'b0;
    else if (dir_chg)  sink_on <= 1'b0;
    else if (bbm_done) sink_on <= 1'b1;
    else if (start)    sink_on <= 1'b1;
    else if (trip)     sink_on <= 1'b0;
  end

  always_comb begin
    gate = '0;
    if (en && !bbm_busy) gate = gate_pattern(dir_q, sink_on);
  end

  assign thr = thr_of(lvl_e'(lvl_s));
endmodule

// File: rtl/stepper_chop_ctrl.sv
module stepper_chop_ctrl
  import stpc_pkg::*;
#(
  parameter int unsigned BBM_CYCLES       = 400,
  parameter int unsigned PHASE_OFS_CYCLES = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_tick,
  input  logic [1:0] dir_in,
  input  logic [3:0] lvl_in,
  input  logic [1:0] trip_in,
  output logic [3:0] hs_en,
  output logic [3:0] ls_en,
  output logic [3:0] thr_sel,
  output logic       inhibit_o
);
  localparam int NB = 2;

  logic [1:0] dir_s;
  logic [3:0] lvl_s;
  logic [1:0] start_b;
  logic [1:0] bbm_busy;
  logic [1:0] bbm_done;

  stpc_sync2 #(.W(6)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({dir_in, lvl_in}),
    .q     ({dir_s, lvl_s})
  );

  stpc_phase_skew #(.OFS_CYC(PHASE_OFS_CYCLES)) u_skew (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (osc_tick),
    .start (start_b)
  );

  assign inhibit_o = (lvl_s == 4'b0000);

  generate
    for (genvar b = 0; b < NB; b++) begin : g_br
      gate_t g;

      stpc_bridge #(.BBM_CYC(BBM_CYCLES)) u_br (
        .clk      (clk),
        .rst_n    (rst_n),
        .dir_s    (dir_s[b]),
        .lvl_s    (lvl_s[2*b +: 2]),
        .start    (start_b[b]),
        .trip     (trip_in[b]),
        .gate     (g),
        .thr      (thr_sel[2*b +: 2]),
        .bbm_busy (bbm_busy[b]),
        .bbm_done (bbm_done[b])
      );

      assign hs_en[2*b]   = g.hi_s1;
      assign hs_en[2*b+1] = g.hi_s2;
      assign ls_en[2*b]   = g.lo_s1;
      assign ls_en[2*b+1] = g.lo_s2;
    end
  endgenerate
endmodule

// File: rtl/stepper_chop_chk.sv
module stepper_chop_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       inhibit_o,
  input logic [3:0] hs_en,
  input logic [3:0] ls_en,
  input logic [3:0] thr_sel,
  input logic [1:0] trip_in,
  input logic [1:0] start_b,
  input logic [1:0] bbm_busy,
  input logic [1:0] bbm_done
);
  p_inhibit_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit_o |-> (hs_en == 4'b0 && ls_en == 4'b0 && thr_sel == 4'b0));

  p_inhibit_codes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_sel != 4'b0) |-> !inhibit_o);

  generate
    for (genvar b = 0; b < 2; b++) begin : g_chk
      p_no_shoot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_en[2*b] && ls_en[2*b]) && !(hs_en[2*b+1] && ls_en[2*b+1]));

      p_idle_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_sel[2*b +: 2] == 2'b00) |-> (hs_en[2*b +: 2] == 2'b00 && ls_en[2*b +: 2] == 2'b00));

      p_bbm_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bbm_busy[b] |-> (hs_en[2*b +: 2] == 2'b00 && ls_en[2*b +: 2] == 2'b00));

      p_trip_cut_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_in[b] && !start_b[b] && !bbm_done[b]) |=> (ls_en[2*b +: 2] == 2'b00));

      p_sink_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_en[2*b +: 2] == 2'b00 && !start_b[b] && !bbm_done[b]) |=> (ls_en[2*b +: 2] == 2'b00));
    end
  endgenerate
endmodule

bind stepper_chop_ctrl stepper_chop_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .inhibit_o (inhibit_o),
  .hs_en     (hs_en),
  .ls_en     (ls_en),
  .thr_sel   (thr_sel),
  .trip_in   (trip_in),
  .start_b   (start_b),
  .bbm_busy  (bbm_busy),
  .bbm_done  (bbm_done)
);

// File: tb/stepper_chop_ctrl_test.sv
module stepper_chop_ctrl_test;
  localparam int BBM = 5;
  localparam int OFS = 7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_tick = 1'b0;
  logic [1:0] dir_in = 2'b00;
  logic [3:0] lvl_in = 4'b0000;
  logic [1:0] trip_in = 2'b00;
  logic [3:0] hs_en, ls_en, thr_sel;
  logic       inhibit_o;

  int n_vec = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  stepper_chop_ctrl #(.BBM_CYCLES(BBM), .PHASE_OFS_CYCLES(OFS)) uut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .dir_in(dir_in),
    .lvl_in(lvl_in), .trip_in(trip_in), .hs_en(hs_en), .ls_en(ls_en),
    .thr_sel(thr_sel), .inhibit_o(inhibit_o)
  );

  task automatic nx(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic pulse_tick();
    osc_tick = 1'b1;
    nx(1);
    osc_tick = 1'b0;
  endtask

  function automatic logic [1:0] want_hs(input logic d, input logic [1:0] c);
    if (c == 2'b00) return 2'b00;
    return d ? 2'b01 : 2'b10;
  endfunction

  function automatic logic [1:0] want_ls(input logic d, input logic [1:0] c);
    if (c == 2'b00) return 2'b00;
    return d ? 2'b10 : 2'b01;
  endfunction

  initial begin
    repeat (60000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [1:0] prev;
    nx(3);
    rst_n = 1'b1;
    nx(1);
    check("R2 reset inhibit", 32'(inhibit_o), 32'd1);
    check("R2 reset hs", 32'(hs_en), 32'd0);
    check("R2 reset ls", 32'(ls_en), 32'd0);
    check("R1 reset thr", 32'(thr_sel), 32'd0);

    // Bridge 0 set level, dir 1; bridge 1 off
    dir_in = 2'b01; lvl_in = 4'b0010;
    nx(BBM + 5);
    check("R4 b0 dir1 hs", 32'(hs_en), 32'b0001);
    check("R4 b0 dir1 ls", 32'(ls_en), 32'b0010);
    check("R1 thr", 32'(thr_sel), 32'b0010);
    check("R3 idle b1", 32'({hs_en[3:2], ls_en[3:2]}), 32'd0);
    check("R2 active", 32'(inhibit_o), 32'd0);

    // Trip bridge 0
    trip_in = 2'b01; nx(1); trip_in = 2'b00;
    check("R7 sink off", 32'(ls_en), 32'd0);
    check("R7 source kept", 32'(hs_en), 32'b0001);
    nx(4);
    check("R7 sink held off", 32'(ls_en), 32'd0);
    pulse_tick();
    check("R6 b0 sink on tick", 32'(ls_en), 32'b0010);

    // Bridge 1 hold level, dir 0
    lvl_in = 4'b0110;
    nx(2);
    check("R10 thr after 2 edges", 32'(thr_sel), 32'b0110);
    check("R4 b1 dir0 hs", 32'(hs_en), 32'b1001);
    check("R6 b1 waits for start", 32'(ls_en), 32'b0010);

    // Staggered start
    trip_in = 2'b11; nx(1); trip_in = 2'b00;
    check("R7 both sinks off", 32'(ls_en), 32'd0);
    pulse_tick();
    check("R6 b0 on first", 32'(ls_en), 32'b0010);
    nx(OFS - 1);
    check("R6 b1 still off", 32'(ls_en), 32'b0010);
    nx(1);
    check("R6 b1 on after offset", 32'(ls_en), 32'b0110);

    // Direction reversal on bridge 0
    dir_in = 2'b00;
    nx(2);
    check("R8 old drive kept", 32'(hs_en), 32'b1001);
    nx(1);
    check("R8 b0 all off first", 32'({hs_en[1:0], ls_en[1:0]}), 32'd0);
    check("R8 b1 untouched", 32'({hs_en[3:2], ls_en[3:2]}), 32'b1001);
    nx(BBM - 1);
    check("R8 b0 all off last", 32'({hs_en[1:0], ls_en[1:0]}), 32'd0);
    nx(1);
    check("R8 b0 new dir", 32'({hs_en[1:0], ls_en[1:0]}), 32'b1001);

    // One-cycle glitch on bridge 1 direction
    dir_in[1] = 1'b1; nx(1); dir_in[1] = 1'b0;
    nx(2);
    check("R9 glitch off start", 32'({hs_en[3:2], ls_en[3:2]}), 32'd0);
    nx(BBM);
    check("R9 glitch off extended", 32'({hs_en[3:2], ls_en[3:2]}), 32'd0);
    nx(1);
    check("R9 glitch resume", 32'({hs_en[3:2], ls_en[3:2]}), 32'b1001);

    // Level latency sweep on bridge 0
    prev = 2'b10;
    for (int c = 0; c < 4; c++) begin
      lvl_in = {2'b01, 2'(c)};
      nx(1);
      check("R10 thr one edge", 32'(thr_sel[1:0]), 32'(prev));
      nx(1);
      check("R1 thr two edges", 32'(thr_sel[1:0]), 32'(c));
      prev = 2'(c);
    end

    // Inhibit entry
    lvl_in = 4'b0000;
    nx(1);
    check("R2 inhibit not yet", 32'(inhibit_o), 32'd0);
    nx(1);
    check("R2 inhibit", 32'(inhibit_o), 32'd1);
    check("R2 inhibit gates", 32'({hs_en, ls_en, thr_sel}), 32'd0);

    // Exhaustive sweep of codes and directions
    for (int d = 0; d < 4; d++) begin
      for (int c = 0; c < 16; c++) begin
        logic [1:0] c0, c1;
        c0 = 2'(c); c1 = 2'(c >> 2);
        dir_in = 2'(d); lvl_in = 4'(c);
        nx(BBM + 5);
        pulse_tick();
        nx(OFS);
        check("R4 sweep hs", 32'(hs_en), 32'({want_hs(d[1], c1), want_hs(d[0], c0)}));
        check("R3 sweep ls", 32'(ls_en), 32'({want_ls(d[1], c1), want_ls(d[0], c0)}));
        check("R1 sweep thr", 32'(thr_sel), 32'(c));
        check("R2 sweep inhibit", 32'(inhibit_o), 32'(c == 0));
        check("R5 sweep no overlap", 32'(hs_en & ls_en), 32'd0);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule